// File: doc/BRIEF.md
# Interrupt Source Configuration and Delivery Router

This block keeps the per-source configuration of a multiprocessor interrupt controller and decides when a request is passed to a processor. Each source has a vector/priority word and a destination word. Both are written and read over a 32-bit register bus in 16-byte steps. Source `s` owns address `s*32`, which holds the vector/priority word, and `s*32 + 16`, which holds the destination word. Each source line has a fixed sense, chosen per source by the `LEVEL_MAP` parameter. A level source requests for as long as its line is high. An edge source latches a rising edge as a pending request.

A single delivery engine visits the sources in turn. It has three states:
- **SCAN** looks at one source per cycle. On the eligible transition it moves to ROUTE. On the advance transition it stays in SCAN and steps to the next source, wrapping from the last source to source 0.
- **ROUTE** picks the target processor from the destination bits in round-robin order. On target-found it moves to DELIVER. On no-target it returns to SCAN.
- **DELIVER** repeats the source checks and applies the processor checks. On the always-return transition it goes back to SCAN and continues after the selected source.

A successful delivery sets the source's activity flag and pulses a one-hot raise strobe to the chosen processor. The strobe carries the source index and its priority. The per-processor acknowledge logic owns each processor's current task priority and its raised set, and this block receives both as inputs. That logic also clears activity flags through `act_clr`.

Top module: `irq_src_router`

## Requirements
- R1: After reset, every vector/priority word holds 0xA0000000, which is masked with priority 0, and reads back with bit 22 added for level sources. Every destination word reads 0.
- R2: A write to a vector/priority word loads bit 31 (mask), bits 19:16 (priority) and bits 7:0 (vector), and clears bit 29. The activity flag at bit 30 does not change on a bus write.
- R3: A write to a destination word keeps bits 31:30 and bits NUM_CPU-1:0, one per processor, and reads back zero in every other bit.
- R4: A write whose address has any of bits 3:0 set changes no register.
- R5: A source with its mask set, priority 0, or destination zero is not delivered. A pending edge request is kept, and it is delivered once the blocking field is rewritten.
- R6: A delivery produces a one-cycle strobe on `raise_stb`, one-hot by processor, with `raise_src` and `raise_pri` valid in the same cycle. From that cycle the activity flag (bit 30) reads 1, and the source is not delivered again while the flag is set.
- R7: A source whose priority is less than or equal to the target processor's task priority is not delivered. A level request stays and is delivered once the task priority drops below the source priority.
- R8: A source whose bit is already set in the target processor's raised set (`cpu_raised` bit `cpu*NUM_SRC + src`) is not delivered. A pending edge request is then discarded.
- R9: With several destination bits set, successive deliveries of one source go to the next set processor after the one it last used, wrapping around. The first delivery after reset goes to the lowest set processor.
- R10: A pulse on `act_clr[s]` clears the source's activity flag and discards its pending edge request. A level source whose line is still high is delivered again.
- R11: Bit 22 of a vector/priority word reads 1 for level sources and 0 for edge sources, fixed by `LEVEL_MAP`. An edge source raises once per rising edge of its line, and holding the line high does not raise it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_SRC | Source request lines |
| act_clr | input | NUM_SRC | Activity clear strobes from acknowledge logic |
| task_pri | input | NUM_CPU*4 | Current task priority, 4 bits per processor |
| cpu_raised | input | NUM_CPU*NUM_SRC | Raised set of each processor, NUM_SRC bits per processor |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | clog2(NUM_SRC)+5 | Register write byte address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | clog2(NUM_SRC)+5 | Register read byte address |
| rd_data | output | 32 | Register read data, combinational |
| raise_stb | output | NUM_CPU | One-hot raise strobe per processor |
| raise_src | output | clog2(NUM_SRC) | Index of the raised source |
| raise_pri | output | 4 | Priority of the raised source |

## Verification
The bench builds the block with 8 sources, 4 processors and `LEVEL_MAP` = 0x0F, so sources 0 to 3 are level-sensed and 4 to 7 are edge-sensed. Both sense paths are then exercised against the same checks: a held level line is delivered again after an activity clear, while an edge pending request is retained or discarded. Four processors allow a destination mask with a gap (processors 0, 1 and 3), so round-robin order can be seen skipping a processor and wrapping from 3 back to 0. Eight sources keep the scan short while still giving each blocking rule its own source.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

    localparam int PRI_W = 4;
    localparam int VEC_W = 8;

    // Bit layout of the vector/priority word
    localparam int VP_MASKED_BIT = 31;
    localparam int VP_ACTIVE_BIT = 30;
    localparam int VP_RSTTAG_BIT = 29;
    localparam int VP_LEVEL_BIT  = 22;
    localparam int VP_PRI_LSB    = 16;

    typedef struct packed {
        logic             masked;
        logic             rst_tag;
        logic [PRI_W-1:0] pri;
        logic [VEC_W-1:0] vec;
    } vp_cfg_t;

    localparam vp_cfg_t VP_CFG_RESET = '{masked: 1'b1, rst_tag: 1'b1, pri: '0, vec: '0};

    typedef enum logic [1:0] {
        ST_SCAN    = 2'd0,
        ST_ROUTE   = 2'd1,
        ST_DELIVER = 2'd2
    } route_state_e;

    function automatic logic [31:0] vp_word(vp_cfg_t c, logic active, logic level);
        logic [31:0] w;
        w = '0;
        w[VP_MASKED_BIT] = c.masked;
        w[VP_ACTIVE_BIT] = active;
        w[VP_RSTTAG_BIT] = c.rst_tag;
        w[VP_LEVEL_BIT]  = level;
        w[VP_PRI_LSB +: PRI_W] = c.pri;
        w[VEC_W-1:0] = c.vec;
        return w;
    endfunction

endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank
    import irq_route_pkg::*;
#(
    parameter int                 NUM_SRC   = 8,
    parameter int                 NUM_CPU   = 4,
    parameter logic [NUM_SRC-1:0] LEVEL_MAP = '1,
    parameter int                 ADDR_W    = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [NUM_SRC-1:0]                irq_in,
    input  logic [NUM_SRC-1:0]                act_clr,
    input  logic [NUM_SRC-1:0]                set_act,
    input  logic [NUM_SRC-1:0]                pend_clr,
    input  logic                              wr_en,
    input  logic [ADDR_W-1:0]                 wr_addr,
    input  logic [31:0]                       wr_data,
    input  logic [ADDR_W-1:0]                 rd_addr,
    output logic [31:0]                       rd_data,
    output logic [NUM_SRC-1:0]                src_masked,
    output logic [NUM_SRC-1:0][PRI_W-1:0]     src_pri,
    output logic [NUM_SRC-1:0][NUM_CPU-1:0]   src_dest,
    output logic [NUM_SRC-1:0]                src_active,
    output logic [NUM_SRC-1:0]                src_req
);

    localparam int SRC_W = $clog2(NUM_SRC);

    vp_cfg_t [NUM_SRC-1:0]              vp_q;
    logic    [NUM_SRC-1:0][1:0]         dtop_q;
    logic    [NUM_SRC-1:0][NUM_CPU-1:0] dcpu_q;
    logic    [NUM_SRC-1:0]              act_q;
    logic    [NUM_SRC-1:0]              pend_q;
    logic    [NUM_SRC-1:0]              irq_q;

    logic             aligned_wr;
    logic [SRC_W-1:0] wr_idx;
    logic             wr_dst_sel;
    logic             unused_bits;

    assign aligned_wr  = wr_en && (wr_addr[3:0] == 4'd0);
    assign wr_idx      = wr_addr[ADDR_W-1:5];
    assign wr_dst_sel  = wr_addr[4];
    assign unused_bits = ^{wr_data[29:20], wr_data[15:8], rd_addr[3:0]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < NUM_SRC; s++) begin
                vp_q[s] <= VP_CFG_RESET;
            end
            dtop_q <= '0;
            dcpu_q <= '0;
            act_q  <= '0;
            pend_q <= '0;
            irq_q  <= '0;
        end else begin
            irq_q <= irq_in;
            for (int s = 0; s < NUM_SRC; s++) begin
                if (aligned_wr && (wr_idx == SRC_W'(s))) begin
                    if (!wr_dst_sel) begin
                        vp_q[s].masked  <= wr_data[VP_MASKED_BIT];
                        vp_q[s].rst_tag <= 1'b0;
                        vp_q[s].pri     <= wr_data[VP_PRI_LSB +: PRI_W];
                        vp_q[s].vec     <= wr_data[VEC_W-1:0];
                    end else begin
                        dtop_q[s] <= wr_data[31:30];
                        dcpu_q[s] <= wr_data[NUM_CPU-1:0];
                    end
                end
                if (set_act[s]) begin
                    act_q[s] <= 1'b1;
                end else if (act_clr[s]) begin
                    act_q[s] <= 1'b0;
                end
                if (!LEVEL_MAP[s] && irq_in[s] && !irq_q[s]) begin
                    pend_q[s] <= 1'b1;
                end else if (pend_clr[s] || act_clr[s]) begin
                    pend_q[s] <= 1'b0;
                end
            end
        end
    end

    logic [NUM_SRC-1:0][31:0] rd_vp;
    logic [NUM_SRC-1:0][31:0] rd_dst;

    for (genvar s = 0; s < NUM_SRC; s++) begin : gen_view
        assign src_req[s]    = LEVEL_MAP[s] ? irq_in[s] : pend_q[s];
        assign src_masked[s] = vp_q[s].masked;
        assign src_pri[s]    = vp_q[s].pri;
        assign src_dest[s]   = dcpu_q[s];
        assign rd_vp[s]      = vp_word(vp_q[s], act_q[s], LEVEL_MAP[s]);
        assign rd_dst[s]     = {dtop_q[s], {(30-NUM_CPU){1'b0}}, dcpu_q[s]};
    end

    assign src_active = act_q;

    always_comb begin
        rd_data = '0;
        for (int s = 0; s < NUM_SRC; s++) begin
            if (rd_addr[ADDR_W-1:5] == SRC_W'(s)) begin
                rd_data = rd_addr[4] ? rd_dst[s] : rd_vp[s];
            end
        end
    end

    // R4
    misaligned_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr[3:0] != 4'd0)) |=> ($stable(vp_q) && $stable(dcpu_q) && $stable(dtop_q)));

    // R2
    act_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((set_act == '0) && (act_clr == '0)) |=> $stable(act_q));

endmodule

// File: rtl/irq_rr_pick.sv
module irq_rr_pick #(
    parameter int N = 4,
    parameter int W = 2
) (
    input  logic [N-1:0] req,
    input  logic [W-1:0] last,
    output logic [W-1:0] pick,
    output logic         found
);

    always_comb begin
        pick  = last;
        found = 1'b0;
        for (int k = 1; k <= N; k++) begin
            int j;
            j = (int'(last) + k) % N;
            if (!found && req[j]) begin
                found = 1'b1;
                pick  = W'(j);
            end
        end
    end

endmodule

// File: rtl/irq_route_fsm.sv
module irq_route_fsm
    import irq_route_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int NUM_CPU = 4,
    parameter int SRC_W   = 3,
    parameter int CPU_W   = 2
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_SRC-1:0]              src_req,
    input  logic [NUM_SRC-1:0]              src_active,
    input  logic [NUM_SRC-1:0]              src_masked,
    input  logic [NUM_SRC-1:0][PRI_W-1:0]   src_pri,
    input  logic [NUM_SRC-1:0][NUM_CPU-1:0] src_dest,
    input  logic [NUM_CPU-1:0][PRI_W-1:0]   cpu_task,
    input  logic [NUM_CPU-1:0][NUM_SRC-1:0] cpu_raised,
    output logic [NUM_SRC-1:0]              set_act,
    output logic [NUM_SRC-1:0]              pend_clr,
    output logic [NUM_CPU-1:0]              raise_stb,
    output logic [SRC_W-1:0]                raise_src,
    output logic [PRI_W-1:0]                raise_pri
);

    route_state_e st_q, st_d;
    logic [SRC_W-1:0] ptr_q, ptr_d;
    logic [SRC_W-1:0] sel_q, sel_d;
    logic [CPU_W-1:0] tgt_q, tgt_d;
    logic [NUM_SRC-1:0][CPU_W-1:0] last_q;
    logic [NUM_SRC-1:0] elig;
    logic deliver, miss;
    logic [CPU_W-1:0] pick;
    logic pick_found;

    // Ordered source checks: mask, zero priority, activity, empty destination
    for (genvar s = 0; s < NUM_SRC; s++) begin : gen_elig
        assign elig[s] = src_req[s] && !src_masked[s] && (src_pri[s] != '0)
                         && !src_active[s] && (src_dest[s] != '0);
    end

    irq_rr_pick #(.N(NUM_CPU), .W(CPU_W)) u_pick (
        .req   (src_dest[sel_q]),
        .last  (last_q[sel_q]),
        .pick  (pick),
        .found (pick_found)
    );

    function automatic logic [SRC_W-1:0] step(logic [SRC_W-1:0] p);
        return (p == SRC_W'(NUM_SRC-1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d    = st_q;
        ptr_d   = ptr_q;
        sel_d   = sel_q;
        tgt_d   = tgt_q;
        deliver = 1'b0;
        miss    = 1'b0;
        unique case (st_q)
            ST_SCAN: begin
                if (elig[ptr_q]) begin
                    sel_d = ptr_q;
                    st_d  = ST_ROUTE;
                end else begin
                    ptr_d = step(ptr_q);
                end
            end
            ST_ROUTE: begin
                if (pick_found) begin
                    tgt_d = pick;
                    st_d  = ST_DELIVER;
                end else begin
                    ptr_d = step(sel_q);
                    st_d  = ST_SCAN;
                end
            end
            ST_DELIVER: begin
                if (elig[sel_q] && src_dest[sel_q][tgt_q]) begin
                    if (cpu_raised[tgt_q][sel_q]) begin
                        miss = 1'b1;
                    end else if (src_pri[sel_q] > cpu_task[tgt_q]) begin
                        deliver = 1'b1;
                    end
                end
                ptr_d = step(sel_q);
                st_d  = ST_SCAN;
            end
            default: st_d = ST_SCAN;
        endcase
    end

    always_comb begin
        set_act  = '0;
        pend_clr = '0;
        if (deliver) set_act[sel_q] = 1'b1;
        if (deliver || miss) pend_clr[sel_q] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_SCAN;
            ptr_q <= '0;
            sel_q <= '0;
            tgt_q <= '0;
        end else begin
            st_q  <= st_d;
            ptr_q <= ptr_d;
            sel_q <= sel_d;
            tgt_q <= tgt_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            raise_stb <= '0;
            raise_src <= '0;
            raise_pri <= '0;
            for (int s = 0; s < NUM_SRC; s++) begin
                last_q[s] <= CPU_W'(NUM_CPU-1);
            end
        end else begin
            raise_stb <= '0;
            if (deliver) begin
                raise_stb[tgt_q] <= 1'b1;
                raise_src        <= sel_q;
                raise_pri        <= src_pri[sel_q];
                last_q[sel_q]    <= tgt_q;
            end
        end
    end

    // R6
    raise_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(raise_stb));

    // R6
    deliver_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_DELIVER) |=> (st_q == ST_SCAN));

    // R5
    raise_pri_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (raise_stb != '0) |-> (raise_pri != '0));

endmodule

// File: rtl/irq_src_router.sv
module irq_src_router
    import irq_route_pkg::*;
#(
    parameter int                 NUM_SRC   = 8,
    parameter int                 NUM_CPU   = 4,
    parameter logic [NUM_SRC-1:0] LEVEL_MAP = '1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_SRC-1:0]            irq_in,
    input  logic [NUM_SRC-1:0]            act_clr,
    input  logic [NUM_CPU*PRI_W-1:0]      task_pri,
    input  logic [NUM_CPU*NUM_SRC-1:0]    cpu_raised,
    input  logic                          wr_en,
    input  logic [$clog2(NUM_SRC)+4:0]    wr_addr,
    input  logic [31:0]                   wr_data,
    input  logic [$clog2(NUM_SRC)+4:0]    rd_addr,
    output logic [31:0]                   rd_data,
    output logic [NUM_CPU-1:0]            raise_stb,
    output logic [$clog2(NUM_SRC)-1:0]    raise_src,
    output logic [PRI_W-1:0]              raise_pri
);

    localparam int SRC_W  = $clog2(NUM_SRC);
    localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1;
    localparam int ADDR_W = SRC_W + 5;

    logic [NUM_CPU-1:0][PRI_W-1:0]   tp;
    logic [NUM_CPU-1:0][NUM_SRC-1:0] cr;
    logic [NUM_SRC-1:0]              set_act, pend_clr, src_masked, src_active, src_req;
    logic [NUM_SRC-1:0][PRI_W-1:0]   src_pri;
    logic [NUM_SRC-1:0][NUM_CPU-1:0] src_dest;

    assign tp = task_pri;
    assign cr = cpu_raised;

    irq_src_bank #(
        .NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU), .LEVEL_MAP(LEVEL_MAP), .ADDR_W(ADDR_W)
    ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .irq_in     (irq_in),
        .act_clr    (act_clr),
        .set_act    (set_act),
        .pend_clr   (pend_clr),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .src_masked (src_masked),
        .src_pri    (src_pri),
        .src_dest   (src_dest),
        .src_active (src_active),
        .src_req    (src_req)
    );

    irq_route_fsm #(
        .NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU), .SRC_W(SRC_W), .CPU_W(CPU_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_req    (src_req),
        .src_active (src_active),
        .src_masked (src_masked),
        .src_pri    (src_pri),
        .src_dest   (src_dest),
        .cpu_task   (tp),
        .cpu_raised (cr),
        .set_act    (set_act),
        .pend_clr   (pend_clr),
        .raise_stb  (raise_stb),
        .raise_src  (raise_src),
        .raise_pri  (raise_pri)
    );

    // R6
    raise_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (raise_stb != '0) |-> src_active[raise_src]);

    for (genvar c = 0; c < NUM_CPU; c++) begin : gen_cpu_chk
        // R7
        task_pri_chk: assert property (@(posedge clk) disable iff (!rst_n)
            raise_stb[c] |-> (raise_pri > $past(tp[c])));

        // R8
        not_raised_chk: assert property (@(posedge clk) disable iff (!rst_n)
            raise_stb[c] |-> ((($past(cr[c])) >> raise_src) & NUM_SRC'(1)) == '0);
    end

endmodule

// File: tb/irq_src_router_bench.sv
module irq_src_router_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NS = 8;
    localparam int NC = 4;
    localparam logic [NS-1:0] LMAP = 8'h0F;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [NS-1:0] irq_in, act_clr;
    logic [NC*4-1:0] task_pri;
    logic [NC*NS-1:0] cpu_raised;
    logic        wr_en;
    logic [7:0]  wr_addr, rd_addr;
    logic [31:0] wr_data, rd_data;
    logic [NC-1:0] raise_stb;
    logic [2:0]  raise_src;
    logic [3:0]  raise_pri;

    int n_vec = 0;
    int n_bad = 0;
    logic [15:0] exp_q[$];
    string       tag_q[$];
    string       cur_tag = "R6";
    bit          done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_src_router #(.NUM_SRC(NS), .NUM_CPU(NC), .LEVEL_MAP(LMAP)) u_irq_src_router (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .act_clr(act_clr),
        .task_pri(task_pri), .cpu_raised(cpu_raised), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .raise_stb(raise_stb), .raise_src(raise_src), .raise_pri(raise_pri)
    );

    // Monitor: compare every raise against the scoreboard queue
    always @(negedge clk) begin
        if (rst_n && raise_stb != '0) begin
            logic [15:0] got;
            got = {raise_stb, raise_pri, 5'd0, raise_src};
            n_vec++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL %s unexpected raise: got stb=%b pri=%0d src=%0d expected none",
                         cur_tag, raise_stb, raise_pri, raise_src);
            end else begin
                logic [15:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (got !== e) begin
                    n_bad++;
                    $display("FAIL %s raise: got stb=%b pri=%0d src=%0d expected stb=%b pri=%0d src=%0d",
                             t, got[15:12], got[11:8], got[7:0], e[15:12], e[11:8], e[7:0]);
                end
            end
        end
    end

    task automatic expect_raise(int cpu, int src, int pri, string tag);
        exp_q.push_back({4'(1 << cpu), 4'(pri), 8'(src)});
        tag_q.push_back(tag);
    endtask

    task automatic drain(string tag);
        for (int i = 0; i < 60 && exp_q.size() != 0; i++) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_vec++;
            n_bad++;
            $display("FAIL %s missing raise: got none expected %0d more", tag, exp_q.size());
            exp_q.delete();
            tag_q.delete();
        end
    endtask

    task automatic quiet(string tag);
        cur_tag = tag;
        repeat (40) @(negedge clk);
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(logic [7:0] a, logic [31:0] e, string tag);
        @(negedge clk);
        rd_addr = a;
        #1;
        n_vec++;
        if (rd_data !== e) begin
            n_bad++;
            $display("FAIL %s read @%h: got %h expected %h", tag, a, rd_data, e);
        end
    endtask

    task automatic pulse_irq(int s);
        @(negedge clk); irq_in[s] = 1'b1;
        repeat (2) @(negedge clk);
        irq_in[s] = 1'b0;
    endtask

    task automatic clr_act(int s);
        @(negedge clk); act_clr[s] = 1'b1;
        @(negedge clk); act_clr[s] = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: got hang expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; irq_in = '0; act_clr = '0; task_pri = '0; cpu_raised = '0;
        wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 / R11 reset words and sense bit
        rd_chk(8'h00, 32'hA040_0000, "R1");
        rd_chk(8'hA0, 32'hA000_0000, "R11");
        rd_chk(8'h30, 32'h0000_0000, "R1");

        // R2 / R3 write masks
        wr(8'h20, 32'hFFFF_FFFF);
        rd_chk(8'h20, 32'h804F_00FF, "R2");
        wr(8'h30, 32'hFFFF_FFFF);
        rd_chk(8'h30, 32'hC000_000F, "R3");

        // R4 misaligned writes
        wr(8'h24, 32'h0);
        rd_chk(8'h20, 32'h804F_00FF, "R4");
        wr(8'h38, 32'h0);
        rd_chk(8'h30, 32'hC000_000F, "R4");

        // R6 level delivery to cpu2
        wr(8'h30, 32'h4);
        wr(8'h20, 32'h0003_00AB);
        rd_chk(8'h20, 32'h0043_00AB, "R2");
        expect_raise(2, 1, 3, "R6");
        @(negedge clk); irq_in[1] = 1'b1;
        drain("R6");
        rd_chk(8'h20, 32'h4043_00AB, "R6");
        quiet("R6");
        wr(8'h20, 32'h0003_00AC);
        rd_chk(8'h20, 32'h4043_00AC, "R2");
        @(negedge clk); irq_in[1] = 1'b0;
        clr_act(1);
        quiet("R10");
        rd_chk(8'h20, 32'h0043_00AC, "R10");

        // R9 round robin over cpus 0,1,3; R10 level re-raise
        wr(8'h50, 32'hB);
        wr(8'h40, 32'h0005_0012);
        expect_raise(0, 2, 5, "R9");
        @(negedge clk); irq_in[2] = 1'b1;
        drain("R9");
        expect_raise(1, 2, 5, "R9");
        clr_act(2);
        drain("R10");
        expect_raise(3, 2, 5, "R9");
        clr_act(2);
        drain("R9");
        expect_raise(0, 2, 5, "R9");
        clr_act(2);
        drain("R9");
        @(negedge clk); irq_in[2] = 1'b0;
        clr_act(2);
        quiet("R10");

        // R7 task priority
        task_pri[3:0] = 4'd5;
        wr(8'h70, 32'h1);
        wr(8'h60, 32'h0005_0033);
        @(negedge clk); irq_in[3] = 1'b1;
        quiet("R7");
        expect_raise(0, 3, 5, "R7");
        task_pri[3:0] = 4'd4;
        drain("R7");
        @(negedge clk); irq_in[3] = 1'b0;
        clr_act(3);
        task_pri = '0;

        // R8 missed, level source
        cpu_raised[3*NS+0] = 1'b1;
        wr(8'h10, 32'h8);
        wr(8'h00, 32'h0009_0000);
        @(negedge clk); irq_in[0] = 1'b1;
        quiet("R8");
        expect_raise(3, 0, 9, "R8");
        cpu_raised[3*NS+0] = 1'b0;
        drain("R8");
        @(negedge clk); irq_in[0] = 1'b0;
        clr_act(0);

        // R11 edge source
        wr(8'h90, 32'h2);
        wr(8'h80, 32'h0007_0044);
        expect_raise(1, 4, 7, "R11");
        @(negedge clk); irq_in[4] = 1'b1;
        drain("R11");
        quiet("R11");
        @(negedge clk); irq_in[4] = 1'b0;
        rd_chk(8'h80, 32'h4007_0044, "R11");
        pulse_irq(4);
        quiet("R10");
        clr_act(4);
        quiet("R10");

        // R8 missed, edge request discarded
        cpu_raised[1*NS+4] = 1'b1;
        pulse_irq(4);
        quiet("R8");
        cpu_raised[1*NS+4] = 1'b0;
        quiet("R8");

        // R5 mask, zero priority, empty destination
        wr(8'hB0, 32'h1);
        wr(8'hA0, 32'h8006_0055);
        pulse_irq(5);
        quiet("R5");
        expect_raise(0, 5, 6, "R5");
        wr(8'hA0, 32'h0006_0055);
        drain("R5");
        clr_act(5);

        wr(8'hD0, 32'h1);
        wr(8'hC0, 32'h0000_0066);
        pulse_irq(6);
        quiet("R5");
        expect_raise(0, 6, 2, "R5");
        wr(8'hC0, 32'h0002_0066);
        drain("R5");
        clr_act(6);

        wr(8'hE0, 32'h0001_0077);
        pulse_irq(7);
        quiet("R5");
        expect_raise(2, 7, 1, "R5");
        wr(8'hF0, 32'h4);
        drain("R5");
        clr_act(7);
        quiet("R5");

        finish_run();
    end

endmodule